// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port that sits behind a simple byte-wide memory-mapped register bus. Each pin has its own direction bit. When the bit is 1 the port drives the pin from an output latch. When the bit is 0 the port samples the pin through a two-flop synchronizer.

The data register is reached through a window of 256 word addresses below byte offset 0x400. The address itself carries a per-pin mask: byte-address bit (n+2) selects pin n. Software can therefore set, clear or sample any subset of pins with one access and no read-modify-write. For pin n alone, the address is `1 << (n+2)`. The direction register sits at byte address 0x400.

Writes take effect on the rising clock edge while the write enable is high. Read data is combinational from the registered state.

Top module: `gpmp_port`

## Requirements
- R1: While reset is asserted and after it is released, the direction register and the output latch are 0. `pin_oe` and `pin_out` are all 0, and every pin starts as an input.
- R2: A write to byte address 0x400 loads the direction register from `bus_wdata` at that clock edge, with 1 meaning output. `pin_oe` follows the register, and a read of 0x400 returns it.
- R3: A write to an address below 0x400 updates the output latch only for pins n whose address bit (n+2) is 1. The latch bits of all other pins keep their value.
- R4: A data write has no effect on the output latch bit of a pin whose direction bit is 0. After that pin is switched to output, `pin_out` shows the value it held before the ignored write.
- R5: A read of an address below 0x400 returns 0 in every bit position n whose address bit (n+2) is 0.
- R6: In a masked data read, an output pin returns its latched value and an input pin returns its synchronized input level.
- R7: A change on `pin_in` is visible in data reads only after two rising clock edges. After one edge the old level is still returned.
- R8: Writes to byte addresses of 0x401 and above change neither register, and reads of those addresses return 0.
- R9: With `bus_we` low, no register changes, whatever the address and write data.
- R10: In the data window, byte-address bits [1:0] do not affect which pins are accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write enable; the write happens at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address and the registered state |
| pin_in | input | 8 | Asynchronous pin input levels |
| pin_out | output | 8 | Output latch values, one per pin |
| pin_oe | output | 8 | Per-pin output enables, equal to the direction register |

## Verification
Register writes are due one rising edge after the write cycle. The bench holds each write for exactly one edge and checks `pin_out`, `pin_oe` and the read-back on the following falling edge. Read data has no latency, so each read is sampled shortly after the address is driven on a falling edge, well away from any clock edge. Pin input changes are due two edges after they are driven. The bench samples once after one edge, where the old level is expected, and once after the second, where the new level is expected. In random runs it always lets two edges pass before the next read.

// File: rtl/gpmp_pkg.sv
`timescale 1ns/1ps
package gpmp_pkg;
  localparam int NPINS  = 8;
  localparam int ADDR_W = 12;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_DIR  = 2'd2
  } acc_kind_t;
endpackage

// File: rtl/gpmp_sync.sv
`timescale 1ns/1ps
module gpmp_sync #(
  parameter int NPINS = gpmp_pkg::NPINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_async,
  output logic [NPINS-1:0] pin_sync
);
  logic [NPINS-1:0] stage1_q;
  logic [NPINS-1:0] stage2_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q[i] <= 1'b0;
        stage2_q[i] <= 1'b0;
      end else begin
        stage1_q[i] <= pin_async[i];
        stage2_q[i] <= stage1_q[i];
      end
    end
  end

  assign pin_sync = stage2_q;

  // warm-up count of edges since reset, used by the latency check
  logic [1:0] warm_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 warm_cnt <= 2'd0;
    else if (warm_cnt != 2'd2)  warm_cnt <= warm_cnt + 2'd1;
  end

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_cnt == 2'd2) |-> (pin_sync == $past(pin_async, 2))); // R7
endmodule

// File: rtl/gpmp_decode.sv
`timescale 1ns/1ps
module gpmp_decode #(
  parameter int NPINS  = gpmp_pkg::NPINS,
  parameter int ADDR_W = gpmp_pkg::ADDR_W
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               we,
  output gpmp_pkg::acc_kind_t kind,
  output logic [NPINS-1:0]   mask,
  output logic               data_wr,
  output logic               dir_wr
);
  import gpmp_pkg::*;

  localparam int WIN_BITS = NPINS + 2;
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(1) << WIN_BITS;

  function automatic acc_kind_t classify(input logic [ADDR_W-1:0] a);
    if (a == DIR_ADDR)                     return ACC_DIR;
    else if (a[ADDR_W-1:WIN_BITS] == '0)   return ACC_DATA;
    else                                   return ACC_NONE;
  endfunction

  function automatic logic [NPINS-1:0] pin_mask(input logic [ADDR_W-1:0] a);
    return a[WIN_BITS-1:2];
  endfunction

  assign kind    = classify(addr);
  assign mask    = pin_mask(addr);
  assign data_wr = we && (kind == ACC_DATA);
  assign dir_wr  = we && (kind == ACC_DIR);
endmodule

// File: rtl/gpmp_regs.sv
`timescale 1ns/1ps
module gpmp_regs #(
  parameter int NPINS = gpmp_pkg::NPINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_wr,
  input  logic             dir_wr,
  input  logic [NPINS-1:0] mask,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] latch_q
);
  function automatic logic [NPINS-1:0] merge_latch(
      input logic [NPINS-1:0] old_v,
      input logic [NPINS-1:0] new_v,
      input logic [NPINS-1:0] sel_m,
      input logic [NPINS-1:0] out_m);
    logic [NPINS-1:0] upd;
    upd = sel_m & out_m;
    return (old_v & ~upd) | (new_v & upd);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dir_q <= '0;
    else if (dir_wr)  dir_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (data_wr)  latch_q <= merge_latch(latch_q, wdata, mask, dir_q);
  end

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr |=> $stable(dir_q)); // R9
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(latch_q)); // R9
  AST_LATCH_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (((latch_q ^ $past(latch_q)) & ~$past(mask)) == '0)); // R3
  AST_LATCH_INPUT_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (((latch_q ^ $past(latch_q)) & ~$past(dir_q)) == '0)); // R4
  AST_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_wr && dir_wr)); // R8
endmodule

// File: rtl/gpmp_rdmux.sv
`timescale 1ns/1ps
module gpmp_rdmux #(
  parameter int NPINS = gpmp_pkg::NPINS
) (
  input  gpmp_pkg::acc_kind_t kind,
  input  logic [NPINS-1:0]    mask,
  input  logic [NPINS-1:0]    dir_q,
  input  logic [NPINS-1:0]    latch_q,
  input  logic [NPINS-1:0]    pin_sync,
  output logic [NPINS-1:0]    rdata
);
  import gpmp_pkg::*;

  function automatic logic [NPINS-1:0] pin_level(
      input logic [NPINS-1:0] d,
      input logic [NPINS-1:0] l,
      input logic [NPINS-1:0] s);
    return (d & l) | (~d & s);
  endfunction

  always_comb begin
    unique case (kind)
      ACC_DIR:  rdata = dir_q;
      ACC_DATA: rdata = mask & pin_level(dir_q, latch_q, pin_sync);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpmp_port.sv
`timescale 1ns/1ps
module gpmp_port #(
  parameter int NPINS  = gpmp_pkg::NPINS,
  parameter int ADDR_W = gpmp_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);
  import gpmp_pkg::*;

  localparam int WIN_BITS = NPINS + 2;

  acc_kind_t        acc_kind;
  logic [NPINS-1:0] acc_mask;
  logic             data_wr;
  logic             dir_wr;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] latch_q;
  logic [NPINS-1:0] pin_sync;

  gpmp_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_in), .pin_sync(pin_sync)
  );

  gpmp_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_decode (
    .addr(bus_addr), .we(bus_we), .kind(acc_kind), .mask(acc_mask),
    .data_wr(data_wr), .dir_wr(dir_wr)
  );

  gpmp_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .dir_wr(dir_wr),
    .mask(acc_mask), .wdata(bus_wdata), .dir_q(dir_q), .latch_q(latch_q)
  );

  gpmp_rdmux #(.NPINS(NPINS)) u_rdmux (
    .kind(acc_kind), .mask(acc_mask), .dir_q(dir_q), .latch_q(latch_q),
    .pin_sync(pin_sync), .rdata(bus_rdata)
  );

  assign pin_out = latch_q;
  assign pin_oe  = dir_q;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (pin_out == '0 && pin_oe == '0)); // R1
  AST_RD_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[ADDR_W-1:WIN_BITS] == '0) |->
      ((bus_rdata & ~bus_addr[WIN_BITS-1:2]) == '0)); // R5
  AST_RD_OUTPIN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[ADDR_W-1:WIN_BITS] == '0) |->
      (((bus_rdata ^ pin_out) & pin_oe & bus_addr[WIN_BITS-1:2]) == '0)); // R6
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == (ADDR_W'(1) << WIN_BITS)) |=> (pin_oe == $past(bus_wdata))); // R2
  AST_OTHER_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > (ADDR_W'(1) << WIN_BITS)) |-> (bus_rdata == '0)); // R8
endmodule

// File: tb/test_gpmp_port.sv
`timescale 1ns/1ps
module test_gpmp_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] m_dir = '0;
  logic [7:0] m_lat = '0;

  always #2.5 clk = ~clk;

  gpmp_port i_gpmp_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [7:0] exp_read(input logic [11:0] a, input logic [7:0] d,
                                          input logic [7:0] l, input logic [7:0] p);
    logic [7:0] r;
    r = 8'h00;
    if (a == 12'h400) return d;
    if (a >= 12'h400) return 8'h00;
    for (int n = 0; n < 8; n++)
      if (a[n+2]) r[n] = d[n] ? l[n] : p[n];
    return r;
  endfunction

  function automatic logic [7:0] exp_latch(input logic [11:0] a, input logic [7:0] v,
                                           input logic [7:0] d, input logic [7:0] l);
    logic [7:0] r;
    r = l;
    if (a < 12'h400)
      for (int n = 0; n < 8; n++)
        if (a[n+2] && d[n]) r[n] = v[n];
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] v);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0;
    m_lat = exp_latch(a, v, m_dir, m_lat);
    if (a == 12'h400) m_dir = v;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 v = rdata;
  endtask

  task automatic set_pins(input logic [7:0] p);
    @(negedge clk);
    pin_in = p;
    repeat (2) @(negedge clk);
  endtask

  logic [7:0] rv;

  initial begin
    void'($urandom(32'd1234));
    pin_in = 8'hA5;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 oe", pin_oe, 8'h00);
    check("R1 out", pin_out, 8'h00);
    addr = 12'h3FC; #1 check("R1 rd", rdata, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(12'h400, rv); check("R1 dir", rv, 8'h00);
    rd(12'h3FC, rv); check("R6 in", rv, 8'hA5);

    // R4: write to an input pin is ignored
    wr(12'h020, 8'hFF);                       // pin 3
    check("R4 out", pin_out, 8'h00);
    wr(12'h400, 8'h08);
    check("R2 oe", pin_oe, 8'h08);
    check("R4 kept", pin_out, 8'h00);
    wr(12'h020, 8'h08);
    check("R3 pin3", pin_out, 8'h08);

    // R3: masked write touches selected pins only
    wr(12'h400, 8'hFF);
    wr(12'h3FC, 8'h3C);
    wr(12'h00C, 8'hFF);                       // pins 0 and 1
    check("R3 mask", pin_out, 8'h3F);
    // R10: low address bits ignored in window
    wr(12'h203, 8'h00);                       // pin 7 plus bits [1:0]
    check("R10 wr", pin_out, 8'h3F);
    wr(12'h202, 8'h80);
    check("R10 wr2", pin_out, 8'hBF);
    rd(12'h201, rv); check("R10 rd", rv, 8'h80);

    // R5 / R6: masked reads and mixed direction
    wr(12'h400, 8'h0F);
    set_pins(8'h5A);
    rd(12'h3FC, rv); check("R6 mix", rv, 8'h5F);
    rd(12'h0F0, rv); check("R5 mask", rv, 8'h1F & 8'h3C | 8'h00);

    // R7: two-edge input latency
    @(negedge clk); pin_in = 8'hC3; addr = 12'h3C0;
    @(negedge clk); #1 check("R7 one edge", rdata, 8'h50);
    @(negedge clk); #1 check("R7 two edges", rdata, 8'hC0);

    // R8: other addresses
    wr(12'h401, 8'hFF); check("R8 oe", pin_oe, 8'h0F);
    wr(12'h800, 8'hFF); check("R8 out", pin_out, m_lat);
    rd(12'h404, rv); check("R8 rd", rv, 8'h00);
    rd(12'hFFC, rv); check("R8 rd2", rv, 8'h00);

    // R9: write enable low
    @(negedge clk); addr = 12'h400; wdata = 8'h00; we = 1'b0;
    @(negedge clk); check("R9 dir", pin_oe, 8'h0F);
    addr = 12'h3FC; wdata = 8'h00;
    @(negedge clk); check("R9 lat", pin_out, m_lat);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [11:0] a;
      logic [7:0] v;
      op = $urandom_range(0, 5);
      v = 8'($urandom);
      case ($urandom_range(0, 3))
        0: a = 12'h400;
        1: a = 12'h400 + 12'($urandom_range(1, 3));
        2: a = 12'($urandom_range(1, 3)) << 10 | 12'($urandom_range(0, 1023));
        default: a = 12'($urandom_range(0, 1023));
      endcase
      if (a == 12'h400 && op > 3) a = 12'h000;
      case (op)
        0, 1: wr(a, v);
        2: set_pins(v);
        default: begin
          rd(a, rv);
          check(a == 12'h400 ? "R2 rd" : (a < 12'h400 ? "R6 rd" : "R8 rd"),
                rv, exp_read(a, m_dir, m_lat, pin_in));
        end
      endcase
      check("R3 out", pin_out, m_lat);
      check("R2 oe", pin_oe, m_dir);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule